// File: doc/BRIEF.md
# Seven-Segment Snake Animator

This block animates one seven-segment digit. A snake three segments long, made of a head, a body and a tail, runs around the six outer segments of the digit. Each of the three parts is kept in its own 3-bit position register. A one-bit direction flag selects clockwise or counter-clockwise travel, and a pseudo-random bit from a shift-register generator chooses that flag again on every move.

The pace comes from a free-running counter that is compared against an 8-bit speed input. A larger speed value gives a slower snake. The compare is a plain equality test. If the speed value is lowered while the counter already holds a higher value, the counter keeps counting until it wraps through zero. Only then can the next move happen.

The seven outputs are active-high segment lines. The middle bar is never lit.

Top module: `snake_anim`

## Requirements
- R1: While `rst_n` is low, and until the second rising `clk` edge after it goes high, the block holds head=2, body=1, tail=0, direction=clockwise and counter=0. The output `seg_o` is therefore 7'b000_0111.
- R2: Position values 0 to 5 light `seg_o` bits 0 to 5 (segments a, b, c, d, e, f), in clockwise order around the ring. Bit 6 (segment g) is always 0.
- R3: `seg_o` is the OR of the one-hot decodes of head, body and tail. Between one and three segments are lit at any time.
- R4: A step occurs on a clock edge where the counter equals `speed_i`. The counter then clears to 0. On any other edge the counter increments, wrapping from 255 to 0. With a constant speed S, steps are S+1 cycles apart.
- R5: The compare is equality only. When `speed_i` is lowered below the current count, no step occurs until the counter has wrapped through zero and reached the new value.
- R6: On a step, tail takes the old body value and body takes the old head value.
- R7: On a step, head moves one position using the direction held before that step. Clockwise (0) moves +1 and wraps 5 to 0. Counter-clockwise (1) moves -1 and wraps 0 to 5.
- R8: On every step, direction loads bit 0 of the 8-bit generator. In the same step the generator shifts left, and its new bit 0 is the XOR of bits 7, 5, 4 and 3. Reset loads the generator with 8'hA5. A change of direction never moves a position by itself.
- R9: Between steps, head, body, tail and direction are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| speed_i | input | 8 | Step interval selector; larger is slower |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g, active high |

## Verification
The assertions assume that `speed_i` changes only between clock edges. They also assume the block sees at least two clean edges after reset is released before any step is judged. The stimulus drives `speed_i` on the falling edge and keeps reset low across several edges.

Stepping is checked under several cases: the fastest setting (0), a medium value, a slow value, and a mid-count drop from 200 to 10. The drop exercises the wrap-through-zero path. Runs are long enough for the random direction to take both values, so both head wrap paths are covered.

// File: rtl/snake_pkg.sv
package snake_pkg;
  localparam int unsigned POS_W   = 3;
  localparam int unsigned RING    = 6;
  localparam int unsigned SEG_N   = 7;
  localparam int unsigned SPEED_W = 8;
  localparam int unsigned RAND_W  = 8;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } dir_e;
endpackage

// File: rtl/snake_pacer.sv
module snake_pacer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] speed,
  output logic             step
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    step  = (cnt_q == speed);
    cnt_d = step ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: without a step the counter advances by one, modulo its width
  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R4: a step restarts the count
  a_r4_clear_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == '0);
endmodule

// File: rtl/snake_lfsr.sv
module snake_lfsr #(
  parameter int unsigned        W        = 8,
  parameter logic [W-1:0]       SEED     = 8'hA5,
  parameter logic [W-1:0]       TAP_MASK = 8'b1011_1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic rnd
);
  logic [W-1:0] q, d;

  always_comb begin
    d = adv ? {q[W-2:0], ^(q & TAP_MASK)} : q;
    rnd = q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= d;
  end

  // R8: the generator never locks up in the all-zero state
  a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
  // R9: the generator is frozen between steps
  a_r9_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/snake_track.sv
module snake_track
  import snake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic rnd,
  output pos_t head,
  output pos_t body,
  output pos_t tail
);
  pos_t head_d, body_d, tail_d;
  dir_e dir_q, dir_d;

  always_comb begin
    head_d = head;
    body_d = body;
    tail_d = tail;
    dir_d  = dir_q;
    if (step) begin
      tail_d = body;
      body_d = head;
      if (dir_q == DIR_CW) head_d = (head == pos_t'(RING-1)) ? '0 : head + 1'b1;
      else                 head_d = (head == '0) ? pos_t'(RING-1) : head - 1'b1;
      dir_d = dir_e'(rnd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= pos_t'(2);
      body  <= pos_t'(1);
      tail  <= pos_t'(0);
      dir_q <= DIR_CW;
    end else begin
      head  <= head_d;
      body  <= body_d;
      tail  <= tail_d;
      dir_q <= dir_d;
    end
  end

  // R2: positions stay on the ring
  a_r2_on_ring: assert property (@(posedge clk) disable iff (!rst_n)
    head < RING && body < RING && tail < RING);
  // R6: body and tail follow the part ahead of them
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> body == $past(head) && tail == $past(body));
  // R7: head always moves on a step
  a_r7_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> head != $past(head));
  // R9: nothing moves between steps
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(head) && $stable(body) && $stable(tail) && $stable(dir_q));
endmodule

// File: rtl/snake_decode.sv
module snake_decode
  import snake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pos_t             head,
  input  pos_t             body,
  input  pos_t             tail,
  output logic [SEG_N-1:0] seg
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    if (i < RING) begin : g_ring
      assign seg[i] = (head == pos_t'(i)) | (body == pos_t'(i)) | (tail == pos_t'(i));
    end else begin : g_dark
      assign seg[i] = 1'b0;
    end
  end

  // R3: one to three segments lit
  a_r3_lit_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg) >= 1 && $countones(seg) <= 3);
  // R3: the head segment is always among the lit ones
  a_r3_head_lit: assert property (@(posedge clk) disable iff (!rst_n)
    seg[head] == 1'b1);
endmodule

// File: rtl/snake_anim.sv
module snake_anim
  import snake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPEED_W-1:0] speed_i,
  output logic [SEG_N-1:0]   seg_o
);
  logic [1:0] rst_sync;
  logic       core_rst_n;
  logic       step;
  logic       rnd;
  pos_t       head, body, tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  snake_pacer #(.CNT_W(SPEED_W)) u_pacer (
    .clk(clk), .rst_n(core_rst_n), .speed(speed_i), .step(step)
  );

  snake_lfsr #(.W(RAND_W)) u_lfsr (
    .clk(clk), .rst_n(core_rst_n), .adv(step), .rnd(rnd)
  );

  snake_track u_track (
    .clk(clk), .rst_n(core_rst_n), .step(step), .rnd(rnd),
    .head(head), .body(body), .tail(tail)
  );

  snake_decode u_decode (
    .clk(clk), .rst_n(core_rst_n),
    .head(head), .body(body), .tail(tail), .seg(seg_o)
  );

  // R2: the middle bar stays dark
  a_r2_g_dark: assert property (@(posedge clk) disable iff (!core_rst_n) !seg_o[SEG_N-1]);
endmodule

// File: tb/sim_snake_anim.sv
module sim_snake_anim;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] speed = 8'd0;
  logic [6:0] seg;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  snake_anim u0 (.clk(clk), .rst_n(rst_n), .speed_i(speed), .seg_o(seg));

  // Expected behaviour built from the requirements
  logic [1:0] m_sync;
  logic [7:0] m_cnt, m_rnd;
  logic [2:0] m_head, m_body, m_tail;
  logic       m_dir;
  bit         saw_cw = 0, saw_ccw = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always @(posedge clk or negedge m_sync[1]) begin
    if (!m_sync[1]) begin
      m_cnt <= 0; m_rnd <= 8'hA5;
      m_head <= 2; m_body <= 1; m_tail <= 0; m_dir <= 0;
    end else if (m_cnt == speed) begin
      m_cnt  <= 0;
      m_tail <= m_body;
      m_body <= m_head;
      if (!m_dir) m_head <= (m_head == 5) ? 3'd0 : m_head + 3'd1;
      else        m_head <= (m_head == 0) ? 3'd5 : m_head - 3'd1;
      m_dir <= m_rnd[0];
      m_rnd <= {m_rnd[6:0], m_rnd[7] ^ m_rnd[5] ^ m_rnd[4] ^ m_rnd[3]};
      if (m_dir) saw_ccw = 1; else saw_cw = 1;
    end else begin
      m_cnt <= m_cnt + 8'd1;
    end
  end

  function automatic logic [6:0] expect_seg();
    logic [6:0] e = '0;
    e[m_head] = 1'b1; e[m_body] = 1'b1; e[m_tail] = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(seg == expect_seg(), req, seg, expect_seg());
      check(seg[6] == 1'b0, "R2 g dark", seg[6], 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; speed = 8'd0;
    repeat (3) @(negedge clk);
    check(seg == 7'h07, "R1 in reset", seg, 7'h07);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg == 7'h07, "R1 first edge after release", seg, 7'h07);
    @(negedge clk);
    check(seg == 7'h07, "R1 second edge after release", seg, 7'h07);
    @(negedge clk);
    // R4 R6 R7: with speed 0 the first step moves head 2->3 clockwise
    check(seg == 7'h0E, "R7 first step clockwise", seg, 7'h0E);
  endtask

  task automatic t_fast();
    speed = 8'd0;
    cmp_cycles(300, "R6 R7 R8 speed 0");
  endtask

  task automatic t_medium();
    speed = 8'd3;
    cmp_cycles(400, "R4 R9 speed 3");
  endtask

  task automatic t_wrap();
    speed = 8'd200;
    do begin
      @(negedge clk);
      check(seg == expect_seg(), "R4 speed 200", seg, expect_seg());
    end while (m_cnt != 8'd150);
    speed = 8'd10;
    begin
      logic [6:0] held = seg;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        check(seg == held, "R5 no step before wrap", seg, held);
      end
    end
    cmp_cycles(200, "R5 step after wrap");
  endtask

  task automatic t_dirs();
    speed = 8'd1;
    cmp_cycles(600, "R7 R8 both directions");
    check(saw_cw && saw_ccw, "R8 direction took both values", {saw_cw, saw_ccw}, 2'b11);
  endtask

  task automatic t_reset_midrun();
    speed = 8'd5;
    cmp_cycles(17, "R9 before reset");
    @(negedge clk); rst_n = 1'b0;
    #1 check(seg == 7'h07, "R1 async reset", seg, 7'h07);
    @(negedge clk); rst_n = 1'b1;
    cmp_cycles(40, "R1 R4 after reset");
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_medium();
    t_wrap();
    t_dirs();
    t_reset_midrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule